// File: doc/BRIEF.md
# Oscillator Failure Guard with Sticky Clock Switchover

This block supervises an external crystal clock. A free-running internal reference clock drives a counter. Every recognised level change of the external clock restarts the count. If the count runs out before the external clock moves again, the block decides that the external clock has failed. At that moment it moves the CPU clock permanently onto the reference clock and raises an interrupt request.

The move is sticky. A recovering crystal does not bring the CPU clock back. Only a hardware reset, or a synchronous software reset request, returns the selection to the external clock. The switch goes through a glitch-free multiplexer, so the CPU clock shows no runt pulse. A status output reports which clock is currently gated through. When supervision is disabled, the CPU clock stays on the external clock and the block drops its enable to the reference source. The reference generator itself is outside the block.

Top module: `osc_fail_guard`

## Requirements
- R1: While `hwRstN` is low, `onRef` and `irqFlag` are 0, `cpuClk` is held low, and `refEn` equals `enable`.
- R2: `extClk` is sampled on every rising edge of `refClk` through a two-stage synchroniser, and a level change is recognised on the third rising edge after it. While `enable` is high, a failure is latched on the rising edge that completes LIMIT (default 16) consecutive edges with no recognised change. An external clock that toggles at least once every LIMIT reference cycles never trips it.
- R3: Once a failure is latched, the failure and the internal clock selection persist when `extClk` resumes toggling, until a reset.
- R4: `onRef` follows the internal selection with a lag of two rising edges of `refClk`. The selection changes on edge n, `onRef` changes at the falling edge after edge n+1, and it is seen after edge n+2. While `onRef` is high, `cpuClk` equals `refClk`.
- R5: `irqFlag` is set on the same rising edge that latches the failure. It stays set until `irqClr` is seen high on a rising edge. If a new failure and `irqClr` arrive on the same edge, the set wins.
- R6: `swRstReq` seen high on a rising edge of `refClk` clears the failure, `irqFlag` and the counter. `onRef` then falls with the R4 lag, and `cpuClk` returns to `extClk`.
- R7: `hwRstN` going low clears `onRef`, `irqFlag` and the latched failure at once, without waiting for a clock edge.
- R8: While `enable` is low, `refEn` is low, the counter is held at zero, no failure can be latched, and the selection is the external clock. A failure latched earlier takes effect again when `enable` returns high.
- R9: The two clock gates of the multiplexer are never open together. With the external clock selected and `extClk` running, `cpuClk` equals `extClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running internal reference clock |
| extClk | input | 1 | External crystal clock under supervision |
| hwRstN | input | 1 | Asynchronous active-low hardware reset |
| enable | input | 1 | Supervision enable; low keeps the external clock and stops the reference source |
| swRstReq | input | 1 | Software reset request, sampled on rising `refClk` |
| irqClr | input | 1 | Clears the interrupt flag, sampled on rising `refClk` |
| cpuClk | output | 1 | Glitch-free selected CPU clock |
| onRef | output | 1 | High while the reference clock drives `cpuClk` |
| irqFlag | output | 1 | Oscillator failure interrupt request |
| refEn | output | 1 | Enable for the reference clock source |

## Verification
The bench aims at the LIMIT boundary. An external clock that toggles every 16 reference cycles must survive, and one that toggles every 17 must trip. A design with an off-by-one in the counter, or one that lost a synchroniser stage, would either miss the failure or fire early, and the per-clock comparison sees the flag on the wrong edge. The bench also restarts the crystal after a failure, clears the interrupt while a failure is being raised, and drops and restores `enable` after a failure. A design that went back to the external clock on its own, let a clear override a set, or forgot the latched failure across a disable would show a wrong `onRef` or `irqFlag`. Finally, it checks `cpuClk` against the chosen clock in both directions. A multiplexer that never released the stalled external branch, or never gated it back in, would leave `cpuClk` flat.

// File: rtl/oscg_pkg.sv
`timescale 1ns/1ps
package oscg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;  // force the silence counter to zero
    logic runCnt;  // counter may advance (no failure latched yet)
    logic selRef;  // registered request to run the CPU on the reference clock
  } guardStrobes_t;
endpackage

// File: rtl/oscg_datapath.sv
`timescale 1ns/1ps
module oscg_datapath
  import oscg_pkg::*;
#(
  parameter int LIMIT       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          refClk,
  input  logic          extClk,
  input  logic          hwRstN,
  input  guardStrobes_t stb,
  output logic          expire,
  output logic          cpuClk,
  output logic          onRef
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

  // Synchroniser chain plus one stage for edge detection
  logic [SYNC_STAGES:0] syncChain;
  logic                 edgeSeen;
  logic [CNT_W-1:0]     silentCnt;

  always_ff @(posedge refClk or negedge hwRstN) begin
    if (!hwRstN) syncChain <= '0;
    else         syncChain <= {syncChain[SYNC_STAGES-1:0], extClk};
  end

  assign edgeSeen = syncChain[SYNC_STAGES] ^ syncChain[SYNC_STAGES-1];
  assign expire   = stb.runCnt && !edgeSeen && (silentCnt == LAST_CNT);

  // Silence counter: restarts on every recognised edge, saturates at expiry
  always_ff @(posedge refClk or negedge hwRstN) begin
    if (!hwRstN)                   silentCnt <= '0;
    else if (stb.clrCnt)           silentCnt <= '0;
    else if (stb.runCnt) begin
      if (edgeSeen)                silentCnt <= '0;
      else if (silentCnt != LAST_CNT) silentCnt <= silentCnt + CNT_W'(1);
    end
  end

  p_cnt_sat_r2: assert property (@(posedge refClk) disable iff (!hwRstN)
    silentCnt <= LAST_CNT);

  // Glitch-free multiplexer. The external branch is killed asynchronously
  // so a stalled crystal cannot block the handover.
  logic killExt;
  logic extArm, extGate;
  logic refArm, refGate;

  assign killExt = stb.selRef | ~hwRstN;

  always_ff @(posedge extClk or posedge killExt) begin
    if (killExt) extArm <= 1'b0;
    else         extArm <= ~refGate;
  end

  always_ff @(negedge extClk or posedge killExt) begin
    if (killExt) extGate <= 1'b0;
    else         extGate <= extArm;
  end

  always_ff @(posedge refClk or negedge hwRstN) begin
    if (!hwRstN) refArm <= 1'b0;
    else         refArm <= stb.selRef & ~extGate;
  end

  always_ff @(negedge refClk or negedge hwRstN) begin
    if (!hwRstN) refGate <= 1'b0;
    else         refGate <= refArm;
  end

  assign cpuClk = (extClk & extGate) | (refClk & refGate);
  assign onRef  = refGate;

  p_gates_excl_r9: assert property (@(posedge refClk) disable iff (!hwRstN)
    !(extGate && refGate));

  p_ref_needs_sel_r4: assert property (@(posedge refClk) disable iff (!hwRstN)
    $rose(refArm) |-> $past(stb.selRef));
endmodule

// File: rtl/oscg_ctrl.sv
`timescale 1ns/1ps
module oscg_ctrl
  import oscg_pkg::*;
(
  input  logic          refClk,
  input  logic          hwRstN,
  input  logic          enable,
  input  logic          swRstReq,
  input  logic          irqClr,
  input  logic          expire,
  output guardStrobes_t stb,
  output logic          irqFlag
);
  logic failed;
  logic selRef;
  logic failNext;
  logic newFail;

  assign failNext = !swRstReq && (failed || (enable && expire));
  assign newFail  = failNext && !failed;

  always_ff @(posedge refClk or negedge hwRstN) begin
    if (!hwRstN) begin
      failed  <= 1'b0;
      selRef  <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      failed <= failNext;
      selRef <= failNext && enable;
      if (swRstReq)    irqFlag <= 1'b0;
      else if (newFail) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
    end
  end

  assign stb.clrCnt = swRstReq | ~enable;
  assign stb.runCnt = ~failed;
  assign stb.selRef = selRef;

  p_sticky_r3: assert property (@(posedge refClk) disable iff (!hwRstN)
    (failed && !swRstReq) |=> failed);

  p_fail_cause_r2: assert property (@(posedge refClk) disable iff (!hwRstN)
    $rose(failed) |-> $past(expire && enable));

  p_irq_hold_r5: assert property (@(posedge refClk) disable iff (!hwRstN)
    (irqFlag && !irqClr && !swRstReq) |=> irqFlag);

  p_swrst_r6: assert property (@(posedge refClk) disable iff (!hwRstN)
    swRstReq |=> (!failed && !irqFlag));
endmodule

// File: rtl/osc_fail_guard.sv
`timescale 1ns/1ps
module osc_fail_guard
  import oscg_pkg::*;
#(
  parameter int LIMIT       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic extClk,
  input  logic hwRstN,
  input  logic enable,
  input  logic swRstReq,
  input  logic irqClr,
  output logic cpuClk,
  output logic onRef,
  output logic irqFlag,
  output logic refEn
);
  guardStrobes_t stb;
  logic          expire;

  oscg_ctrl u_ctrl (
    .refClk  (refClk),
    .hwRstN  (hwRstN),
    .enable  (enable),
    .swRstReq(swRstReq),
    .irqClr  (irqClr),
    .expire  (expire),
    .stb     (stb),
    .irqFlag (irqFlag)
  );

  oscg_datapath #(.LIMIT(LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .refClk(refClk),
    .extClk(extClk),
    .hwRstN(hwRstN),
    .stb   (stb),
    .expire(expire),
    .cpuClk(cpuClk),
    .onRef (onRef)
  );

  assign refEn = enable;

  p_refen_r8: assert property (@(posedge refClk) disable iff (!hwRstN)
    !refEn |-> !irqFlag || $past(irqFlag));
endmodule

// File: tb/osc_fail_guard_test.sv
`timescale 1ns/1ps
module osc_fail_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic refClk = 1'b0;
  logic extClk = 1'b0;
  logic hwRstN;
  logic enable, swRstReq, irqClr;
  logic cpuClk, onRef, irqFlag, refEn;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;
  string curReq = "R1";

  // External clock generator
  bit extRun  = 0;
  int extHalf = 2;
  int extTick = 0;

  // Behavioural reference model
  logic m1 = 0, m2 = 0, m3 = 0;
  int   quiet = 0;
  logic mFail = 0, mIrq = 0, mSel = 0, sel1 = 0, sel2 = 0;
  int   refSteady = 0, extSteady = 0;

  osc_fail_guard #(.LIMIT(LIMIT)) uut (
    .refClk(refClk), .extClk(extClk), .hwRstN(hwRstN), .enable(enable),
    .swRstReq(swRstReq), .irqClr(irqClr), .cpuClk(cpuClk), .onRef(onRef),
    .irqFlag(irqFlag), .refEn(refEn)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  always begin
    @(negedge refClk);
    #2;
    if (extRun) begin
      extTick++;
      if (extTick >= extHalf) begin
        extClk  = ~extClk;
        extTick = 0;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge refClk or negedge hwRstN) begin
    if (!hwRstN) begin
      m1 = 0; m2 = 0; m3 = 0; quiet = 0;
      mFail = 0; mIrq = 0; mSel = 0; sel1 = 0; sel2 = 0;
      refSteady = 0; extSteady = 0;
    end else begin
      bit edgeNow, newF;
      edgeNow = (m2 != m3);
      m3 = m2; m2 = m1; m1 = extClk;
      sel2 = sel1; sel1 = mSel;
      newF = 0;
      if (swRstReq) begin
        mFail = 0; mIrq = 0; quiet = 0;
      end else begin
        if (!enable) quiet = 0;
        else if (!mFail) begin
          if (edgeNow) quiet = 0;
          else quiet++;
          if (quiet >= LIMIT) begin mFail = 1; newF = 1; end
        end
        if (newF) mIrq = 1;
        else if (irqClr) mIrq = 0;
      end
      mSel = enable && mFail;
      refSteady = sel2 ? refSteady + 1 : 0;
      extSteady = (!sel2 && extRun && extHalf == 2) ? extSteady + 1 : 0;
    end
  end

  // Per-clock comparison against the model
  always @(posedge refClk) begin
    #3;
    if (hwRstN === 1'b1 && !done) begin
      chk(curReq, irqFlag, mIrq, "irqFlag");
      chk(curReq, onRef, sel2, "onRef");
      chk(curReq, refEn, enable, "refEn");
      if (refSteady >= 2) chk("R4", cpuClk, 1'b1, "cpuClk high phase on ref");
      if (extSteady >= 12) chk("R9", cpuClk, extClk, "cpuClk follows ext");
    end
  end

  always @(negedge refClk) begin
    #3;
    if (hwRstN === 1'b1 && !done && refSteady >= 2)
      chk("R4", cpuClk, 1'b0, "cpuClk low phase on ref");
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++; checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    hwRstN = 0; enable = 1; swRstReq = 0; irqClr = 0;
    // R1 reset state
    #23;
    chk("R1", onRef, 1'b0, "onRef in reset");
    chk("R1", irqFlag, 1'b0, "irqFlag in reset");
    chk("R1", cpuClk, 1'b0, "cpuClk in reset");
    chk("R1", refEn, 1'b1, "refEn in reset");
    cycles(2);
    hwRstN = 1; extRun = 1; extHalf = 2; curReq = "R9";
    cycles(40);
    // R2: slow but alive clock at the boundary
    curReq = "R2"; extHalf = LIMIT;
    cycles(80); #4;
    chk("R2", irqFlag, 1'b0, "no trip at LIMIT spacing");
    cycles(1);
    extHalf = LIMIT + 1;
    cycles(60); #4;
    chk("R2", irqFlag, 1'b1, "trip at LIMIT+1 spacing");
    chk("R4", onRef, 1'b1, "onRef after trip");
    // R3: crystal resumes, selection stays
    cycles(1);
    curReq = "R3"; extHalf = 2;
    cycles(40); #4;
    chk("R3", onRef, 1'b1, "sticky selection");
    // R5: clear the flag
    cycles(1);
    curReq = "R5"; irqClr = 1;
    cycles(1); irqClr = 0;
    cycles(3); #4;
    chk("R5", irqFlag, 1'b0, "irq cleared");
    chk("R3", onRef, 1'b1, "selection kept after clear");
    // R6: software reset returns to external
    cycles(1);
    curReq = "R6"; swRstReq = 1;
    cycles(1); swRstReq = 0;
    cycles(20); #4;
    chk("R6", onRef, 1'b0, "back on ext");
    chk("R6", irqFlag, 1'b0, "irq after swrst");
    cycles(1);
    curReq = "R9";
    cycles(20);
    // R7: async hardware reset after a failure
    curReq = "R2"; extRun = 0;
    cycles(30); #4;
    chk("R2", irqFlag, 1'b1, "stopped clock trips");
    cycles(1);
    hwRstN = 0; #1;
    chk("R7", onRef, 1'b0, "async clear onRef");
    chk("R7", irqFlag, 1'b0, "async clear irq");
    enable = 0;
    cycles(3);
    // R8: disabled
    hwRstN = 1; curReq = "R8";
    cycles(60); #4;
    chk("R8", irqFlag, 1'b0, "no trip when disabled");
    chk("R8", refEn, 1'b0, "reference off");
    chk("R8", onRef, 1'b0, "external when disabled");
    // R5 set priority with clear held high
    cycles(1);
    curReq = "R5"; irqClr = 1; enable = 1;
    cycles(30); #4;
    chk("R2", onRef, 1'b1, "trip after enable");
    cycles(1);
    irqClr = 0; curReq = "R8"; enable = 0;
    cycles(4); #4;
    chk("R8", onRef, 1'b0, "disable forces ext");
    cycles(1);
    enable = 1;
    cycles(4); #4;
    chk("R8", onRef, 1'b1, "latched failure reapplies");
    cycles(1);
    curReq = "R6"; swRstReq = 1;
    cycles(1); swRstReq = 0;
    cycles(5);
    summary();
    $finish;
  end
endmodule